// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block is the hazard-resolution control for a five-stage, in-order integer pipeline with fetch, decode/register-read, execute, memory and writeback stages. Each cycle it looks at the register numbers held in the pipeline registers: the decode sources, the execute-stage sources and destination, and the destinations of the memory and writeback stages. It also looks at their write enables, the load flags and the decode-resolved branch outcome. From these it produces the operand-forwarding selects for the execute-stage ALU inputs and the forwarding selects for the decode-stage branch comparator. It also drives the hold controls for the program counter and the fetch/decode register, the bubble control for the decode/execute register, and the squash control for the wrong-path fetched instruction.

The controller is purely combinational. It sits beside the datapath multiplexers and the pipeline registers and drives them directly. Fetch always continues sequentially. A taken branch is resolved in decode and discards the single instruction fetched behind it. When an instruction is stalled, the bubble sent into execute is the all-zero instruction word, which acts as a no-operation. The register file writes early in a cycle and reads late, so a reader three instructions behind a writer gets its value from the file. Write-after-write and write-after-read orderings cannot arise in this pipeline and are not detected. Both decode sources are treated as read, so a hazard check on an unused source is conservative.

Stall cause is a priority-encoded enumeration. The causes are: none, load-use, branch waiting on an execute-stage writer, and branch waiting on a load in memory. The first cause that applies is used, in that order.

Top module: `hazard_ctrl`

## Requirements
- R1: An execute-stage source that equals the memory-stage destination, with the memory-stage write enable high and the register nonzero, selects code 2'b10 (memory-stage result) on its forward output.
- R2: An execute-stage source that matches only the writeback-stage destination, with that write enable high and the register nonzero, selects code 2'b01 (writeback result).
- R3: When both the memory-stage and the writeback-stage destinations match a source, the younger memory-stage result wins and the code is 2'b10.
- R4: Register 0 is never a forwarding source (code 2'b00), and a write to register 0 never causes a stall.
- R5: With no enabled match in the memory or writeback stage, an execute forward code is 2'b00 (register file). A decode branch source written only by the writeback stage neither stalls nor forwards.
- R6: A load in execute whose destination equals either decode source raises pc_hold, ifid_hold and idex_bubble together for that cycle. Once the load has moved to memory, a non-branch consumer is no longer held, so the stall lasts exactly one cycle. The consumer then reaches execute with code 2'b01.
- R7: A non-load writer in execute whose destination matches a decode source of a non-branch instruction causes no stall.
- R8: A branch in decode whose source equals the destination of any enabled writer in execute, load or ALU, is stalled.
- R9: A branch whose source equals the destination of a load in memory is stalled. If the memory-stage writer is not a load, no stall occurs and br_fwd_a or br_fwd_b (1 = memory-stage result) is raised for the matching source.
- R10: ifid_flush is 1 exactly when a branch in decode is resolved taken and no stall is raised that cycle. The stall outputs pc_hold, ifid_hold and idex_bubble are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | 5 | Decode-stage first source register |
| id_rs2 | input | 5 | Decode-stage second source register |
| id_is_branch | input | 1 | Decode-stage instruction is a conditional branch |
| id_br_taken | input | 1 | Branch comparison result in decode (1 = taken) |
| ex_rs1 | input | 5 | Execute-stage first source register |
| ex_rs2 | input | 5 | Execute-stage second source register |
| ex_rd | input | 5 | Execute-stage destination register |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | 5 | Memory-stage destination register |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | 5 | Writeback-stage destination register |
| wb_wen | input | 1 | Writeback-stage instruction writes a register |
| ex_fwd_a | output | 2 | Execute operand A select: 00 file, 01 writeback, 10 memory stage |
| ex_fwd_b | output | 2 | Execute operand B select, same coding |
| br_fwd_a | output | 1 | Decode comparator A takes the memory-stage result |
| br_fwd_b | output | 1 | Decode comparator B takes the memory-stage result |
| pc_hold | output | 1 | Keep the program counter unchanged |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Load the all-zero no-operation into decode/execute |
| ifid_flush | output | 1 | Replace the fetched wrong-path instruction with a no-operation |

## Verification
The hardest situation to reach from the ports is the cycle sequence of a load-use stall. The hold must last one cycle and then stop, and the held consumer must then arrive in execute with a writeback forward rather than a memory-stage one. That depends on what the pipeline registers hold in consecutive cycles, not on one input pattern. The bench therefore drives a small behavioural pipeline of register numbers that obeys the hold and bubble outputs. It runs a load followed by three dependent instructions through it and checks the stall count and the forward codes seen as each consumer enters execute. Single-cycle patterns, such as branch dependencies on each stage, register 0 and the priority between stages, come from a vector table.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

    // Operand source selects for execute-stage and decode-stage muxes.
    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;

    // Why the front of the pipeline is held this cycle, in priority order.
    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'd0,
        CAUSE_LOAD_USE = 2'd1,
        CAUSE_BR_EX    = 2'd2,
        CAUSE_BR_MEMLD = 2'd3
    } stall_cause_e;

endpackage

// File: rtl/hzc_src_fwd.sv
module hzc_src_fwd
    import hzc_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_wen,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_wen,
    output fwd_sel_e      sel
);

    localparam logic [AW-1:0] ZERO_REG = '0;

    logic hit_mem;
    logic hit_wb;

    always_comb begin
        hit_mem = (src != ZERO_REG) && mem_wen && (mem_rd == src);
        hit_wb  = (src != ZERO_REG) && wb_wen  && (wb_rd  == src);
    end

    // Younger producer has priority over older one.
    always_comb begin
        unique case ({hit_mem, hit_wb})
            2'b10, 2'b11: sel = FWD_MEM;
            2'b01:        sel = FWD_WB;
            default:      sel = FWD_RF;
        endcase
    end

endmodule

// File: rtl/hzc_stall_detect.sv
module hzc_stall_detect
    import hzc_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic          id_is_branch,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_wen,
    input  logic          ex_is_load,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_wen,
    input  logic          mem_is_load,
    output stall_cause_e  cause
);

    localparam int NSRC = 2;
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic [AW-1:0] srcs [NSRC];
    logic [NSRC-1:0] dep_ex;
    logic [NSRC-1:0] dep_mem;

    assign srcs[0] = id_rs1;
    assign srcs[1] = id_rs2;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign dep_ex[i]  = ex_wen  && (ex_rd  != ZERO_REG) && (ex_rd  == srcs[i]);
        assign dep_mem[i] = mem_wen && (mem_rd != ZERO_REG) && (mem_rd == srcs[i]);
    end

    logic load_use;
    logic br_ex;
    logic br_memld;

    always_comb begin
        load_use = ex_is_load && (|dep_ex);
        br_ex    = id_is_branch && (|dep_ex);
        br_memld = id_is_branch && mem_is_load && (|dep_mem);
    end

    always_comb begin
        unique casez ({load_use, br_ex, br_memld})
            3'b1??:  cause = CAUSE_LOAD_USE;
            3'b01?:  cause = CAUSE_BR_EX;
            3'b001:  cause = CAUSE_BR_MEMLD;
            default: cause = CAUSE_NONE;
        endcase
    end

endmodule

// File: rtl/hzc_decode_ctl.sv
module hzc_decode_ctl
    import hzc_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic          id_is_branch,
    input  logic          id_br_taken,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_wen,
    input  logic          mem_is_load,
    input  stall_cause_e  cause,
    output logic          br_fwd_a,
    output logic          br_fwd_b,
    output logic          pc_hold,
    output logic          ifid_hold,
    output logic          idex_bubble,
    output logic          ifid_flush
);

    localparam logic [AW-1:0] ZERO_REG = '0;

    logic alu_in_mem;

    always_comb begin
        alu_in_mem = mem_wen && !mem_is_load && (mem_rd != ZERO_REG);
        br_fwd_a   = alu_in_mem && (mem_rd == id_rs1);
        br_fwd_b   = alu_in_mem && (mem_rd == id_rs2);
    end

    always_comb begin
        pc_hold     = 1'b0;
        ifid_hold   = 1'b0;
        idex_bubble = 1'b0;
        ifid_flush  = 1'b0;
        unique case (cause)
            CAUSE_NONE: begin
                ifid_flush = id_is_branch && id_br_taken;
            end
            CAUSE_LOAD_USE, CAUSE_BR_EX, CAUSE_BR_MEMLD: begin
                pc_hold     = 1'b1;
                ifid_hold   = 1'b1;
                idex_bubble = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
    import hzc_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic          id_is_branch,
    input  logic          id_br_taken,
    input  logic [AW-1:0] ex_rs1,
    input  logic [AW-1:0] ex_rs2,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_wen,
    input  logic          ex_is_load,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_wen,
    input  logic          mem_is_load,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_wen,
    output logic [1:0]    ex_fwd_a,
    output logic [1:0]    ex_fwd_b,
    output logic          br_fwd_a,
    output logic          br_fwd_b,
    output logic          pc_hold,
    output logic          ifid_hold,
    output logic          idex_bubble,
    output logic          ifid_flush
);

    localparam int NOPS = 2;

    logic [AW-1:0] ex_src [NOPS];
    fwd_sel_e      ex_sel [NOPS];
    stall_cause_e  cause;

    assign ex_src[0] = ex_rs1;
    assign ex_src[1] = ex_rs2;

    for (genvar k = 0; k < NOPS; k++) begin : g_opnd
        hzc_src_fwd #(.AW(AW)) u_fwd (
            .src     (ex_src[k]),
            .mem_rd  (mem_rd),
            .mem_wen (mem_wen),
            .wb_rd   (wb_rd),
            .wb_wen  (wb_wen),
            .sel     (ex_sel[k])
        );
    end

    assign ex_fwd_a = ex_sel[0];
    assign ex_fwd_b = ex_sel[1];

    hzc_stall_detect #(.AW(AW)) u_stall (
        .id_rs1       (id_rs1),
        .id_rs2       (id_rs2),
        .id_is_branch (id_is_branch),
        .ex_rd        (ex_rd),
        .ex_wen       (ex_wen),
        .ex_is_load   (ex_is_load),
        .mem_rd       (mem_rd),
        .mem_wen      (mem_wen),
        .mem_is_load  (mem_is_load),
        .cause        (cause)
    );

    hzc_decode_ctl #(.AW(AW)) u_dec (
        .id_rs1       (id_rs1),
        .id_rs2       (id_rs2),
        .id_is_branch (id_is_branch),
        .id_br_taken  (id_br_taken),
        .mem_rd       (mem_rd),
        .mem_wen      (mem_wen),
        .mem_is_load  (mem_is_load),
        .cause        (cause),
        .br_fwd_a     (br_fwd_a),
        .br_fwd_b     (br_fwd_b),
        .pc_hold      (pc_hold),
        .ifid_hold    (ifid_hold),
        .idex_bubble  (idex_bubble),
        .ifid_flush   (ifid_flush)
    );

endmodule

// File: rtl/hazard_ctrl_chk.sv
module hazard_ctrl_chk #(
    parameter int AW = 5
) (
    input logic [AW-1:0] id_rs1,
    input logic [AW-1:0] id_rs2,
    input logic          id_is_branch,
    input logic          id_br_taken,
    input logic [AW-1:0] ex_rs1,
    input logic [AW-1:0] ex_rd,
    input logic          ex_wen,
    input logic          ex_is_load,
    input logic [AW-1:0] mem_rd,
    input logic          mem_wen,
    input logic [AW-1:0] wb_rd,
    input logic          wb_wen,
    input logic [1:0]    ex_fwd_a,
    input logic [1:0]    ex_fwd_b,
    input logic          pc_hold,
    input logic          ifid_hold,
    input logic          idex_bubble,
    input logic          ifid_flush
);

    localparam logic [AW-1:0] ZERO_REG = '0;

    always_comb begin
        assert_code_legal_R1: assert (ex_fwd_a != 2'b11 && ex_fwd_b != 2'b11)
            else $error("reserved forward code");
        assert_younger_wins_R3: assert (!(ex_rs1 != ZERO_REG && mem_wen && mem_rd == ex_rs1
                                          && wb_wen && wb_rd == ex_rs1) || ex_fwd_a == 2'b10)
            else $error("older result chosen over younger");
        assert_zero_not_fwd_R4: assert (ex_rs1 != ZERO_REG || ex_fwd_a == 2'b00)
            else $error("register 0 forwarded");
        assert_load_use_held_R6: assert (!(ex_is_load && ex_wen && ex_rd != ZERO_REG
                                           && (ex_rd == id_rs1 || ex_rd == id_rs2)) || idex_bubble)
            else $error("load-use not stalled");
        assert_holds_agree_R10: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble)
            else $error("stall controls disagree");
        assert_flush_needs_branch_R10: assert (!ifid_flush || (id_is_branch && id_br_taken && !pc_hold))
            else $error("flush without unstalled taken branch");
    end

endmodule

bind hazard_ctrl hazard_ctrl_chk #(.AW(AW)) u_chk (
    .id_rs1       (id_rs1),
    .id_rs2       (id_rs2),
    .id_is_branch (id_is_branch),
    .id_br_taken  (id_br_taken),
    .ex_rs1       (ex_rs1),
    .ex_rd        (ex_rd),
    .ex_wen       (ex_wen),
    .ex_is_load   (ex_is_load),
    .mem_rd       (mem_rd),
    .mem_wen      (mem_wen),
    .wb_rd        (wb_rd),
    .wb_wen       (wb_wen),
    .ex_fwd_a     (ex_fwd_a),
    .ex_fwd_b     (ex_fwd_b),
    .pc_hold      (pc_hold),
    .ifid_hold    (ifid_hold),
    .idex_bubble  (idex_bubble),
    .ifid_flush   (ifid_flush)
);

// File: tb/hazard_ctrl_tb.sv
module hazard_ctrl_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic id_is_branch, id_br_taken, ex_wen, ex_is_load, mem_wen, mem_is_load, wb_wen;
    logic [1:0] ex_fwd_a, ex_fwd_b;
    logic br_fwd_a, br_fwd_b, pc_hold, ifid_hold, idex_bubble, ifid_flush;

    hazard_ctrl u_dut (
        .id_rs1(id_rs1), .id_rs2(id_rs2), .id_is_branch(id_is_branch), .id_br_taken(id_br_taken),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
        .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_is_load(mem_is_load),
        .wb_rd(wb_rd), .wb_wen(wb_wen),
        .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b), .br_fwd_a(br_fwd_a), .br_fwd_b(br_fwd_b),
        .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble), .ifid_flush(ifid_flush)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic [4:0] irs1; logic [4:0] irs2; logic br; logic tk;
        logic [4:0] ers1; logic [4:0] ers2; logic [4:0] erd; logic ewen; logic eld;
        logic [4:0] mrd; logic mwen; logic mld;
        logic [4:0] wrd; logic wwen;
        logic [1:0] fa; logic [1:0] fb; logic bfa; logic bfb; logic stall; logic flush;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{5'd10,5'd11,1'b0,1'b0, 5'd3,5'd7, 5'd0,1'b0,1'b0, 5'd3,1'b1,1'b0, 5'd0,1'b0, 2'd2,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd1}, // R1 operand A
        '{5'd10,5'd11,1'b0,1'b0, 5'd7,5'd3, 5'd0,1'b0,1'b0, 5'd3,1'b1,1'b0, 5'd0,1'b0, 2'd0,2'd2,1'b0,1'b0,1'b0,1'b0, 4'd1}, // R1 operand B
        '{5'd10,5'd11,1'b0,1'b0, 5'd9,5'd7, 5'd0,1'b0,1'b0, 5'd0,1'b0,1'b0, 5'd9,1'b1, 2'd1,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd2}, // R2 operand A
        '{5'd10,5'd11,1'b0,1'b0, 5'd7,5'd9, 5'd0,1'b0,1'b0, 5'd9,1'b0,1'b0, 5'd9,1'b1, 2'd0,2'd1,1'b0,1'b0,1'b0,1'b0, 4'd2}, // R2 mem match disabled
        '{5'd10,5'd11,1'b0,1'b0, 5'd4,5'd4, 5'd0,1'b0,1'b0, 5'd4,1'b1,1'b0, 5'd4,1'b1, 2'd2,2'd2,1'b0,1'b0,1'b0,1'b0, 4'd3}, // R3 younger wins
        '{5'd10,5'd11,1'b0,1'b0, 5'd0,5'd0, 5'd0,1'b0,1'b0, 5'd0,1'b1,1'b0, 5'd0,1'b1, 2'd0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd4}, // R4 no fwd of x0
        '{5'd0,5'd0,1'b1,1'b0, 5'd1,5'd2, 5'd0,1'b1,1'b1, 5'd0,1'b1,1'b1, 5'd0,1'b0, 2'd0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd4}, // R4 no stall on x0
        '{5'd10,5'd11,1'b0,1'b0, 5'd5,5'd6, 5'd0,1'b0,1'b0, 5'd5,1'b0,1'b0, 5'd6,1'b0, 2'd0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd5}, // R5 no enabled match
        '{5'd8,5'd11,1'b0,1'b0, 5'd0,5'd0, 5'd8,1'b1,1'b1, 5'd0,1'b0,1'b0, 5'd0,1'b0, 2'd0,2'd0,1'b0,1'b0,1'b1,1'b0, 4'd6}, // R6 load-use rs1
        '{5'd11,5'd8,1'b0,1'b0, 5'd0,5'd0, 5'd8,1'b1,1'b1, 5'd0,1'b0,1'b0, 5'd0,1'b0, 2'd0,2'd0,1'b0,1'b0,1'b1,1'b0, 4'd6}, // R6 load-use rs2
        '{5'd8,5'd11,1'b0,1'b0, 5'd0,5'd0, 5'd8,1'b1,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0, 2'd0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd7}, // R7 ALU in ex
        '{5'd8,5'd11,1'b0,1'b0, 5'd0,5'd0, 5'd0,1'b0,1'b0, 5'd8,1'b1,1'b1, 5'd0,1'b0, 2'd0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd6}, // R6 load moved on
        '{5'd12,5'd11,1'b1,1'b1, 5'd0,5'd0, 5'd12,1'b1,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0, 2'd0,2'd0,1'b0,1'b0,1'b1,1'b0, 4'd8}, // R8 branch on ALU in ex
        '{5'd11,5'd12,1'b1,1'b0, 5'd0,5'd0, 5'd12,1'b1,1'b1, 5'd0,1'b0,1'b0, 5'd0,1'b0, 2'd0,2'd0,1'b0,1'b0,1'b1,1'b0, 4'd8}, // R8 branch on load in ex
        '{5'd13,5'd11,1'b1,1'b1, 5'd0,5'd0, 5'd0,1'b0,1'b0, 5'd13,1'b1,1'b1, 5'd0,1'b0, 2'd0,2'd0,1'b0,1'b0,1'b1,1'b0, 4'd9}, // R9 load in mem
        '{5'd13,5'd11,1'b1,1'b1, 5'd0,5'd0, 5'd0,1'b0,1'b0, 5'd13,1'b1,1'b0, 5'd0,1'b0, 2'd0,2'd0,1'b1,1'b0,1'b0,1'b1, 4'd9}, // R9 ALU in mem fwd A
        '{5'd11,5'd14,1'b1,1'b0, 5'd0,5'd0, 5'd0,1'b0,1'b0, 5'd14,1'b1,1'b0, 5'd0,1'b0, 2'd0,2'd0,1'b0,1'b1,1'b0,1'b0, 4'd9}, // R9 ALU in mem fwd B
        '{5'd10,5'd11,1'b1,1'b1, 5'd0,5'd0, 5'd0,1'b0,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0, 2'd0,2'd0,1'b0,1'b0,1'b0,1'b1, 4'd10}, // R10 taken
        '{5'd10,5'd11,1'b1,1'b0, 5'd0,5'd0, 5'd0,1'b0,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0, 2'd0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd10}, // R10 not taken
        '{5'd10,5'd11,1'b0,1'b1, 5'd0,5'd0, 5'd0,1'b0,1'b0, 5'd0,1'b0,1'b0, 5'd0,1'b0, 2'd0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd10}, // R10 not a branch
        '{5'd15,5'd11,1'b1,1'b0, 5'd0,5'd0, 5'd0,1'b0,1'b0, 5'd0,1'b0,1'b0, 5'd15,1'b1, 2'd0,2'd0,1'b0,1'b0,1'b0,1'b0, 4'd5}  // R5 branch on wb writer
    };

    typedef struct packed {
        logic [4:0] rs1; logic [4:0] rs2; logic [4:0] rd; logic wen; logic ld; logic [3:0] tag;
    } ins_t;

    ins_t s_id, s_ex, s_mem, s_wb;

    task automatic drive_model();
        id_rs1 = s_id.rs1; id_rs2 = s_id.rs2; id_is_branch = 1'b0; id_br_taken = 1'b0;
        ex_rs1 = s_ex.rs1; ex_rs2 = s_ex.rs2; ex_rd = s_ex.rd; ex_wen = s_ex.wen; ex_is_load = s_ex.ld;
        mem_rd = s_mem.rd; mem_wen = s_mem.wen; mem_is_load = s_mem.ld;
        wb_rd = s_wb.rd; wb_wen = s_wb.wen;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        ins_t prog [4];
        int pc;
        int stalls;
        s_id = '0; s_ex = '0; s_mem = '0; s_wb = '0;
        drive_model();
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // Reset state: pipeline of no-operations gives idle controls (R5, R10)
        #5;
        check("R5", "reset fwd_a", ex_fwd_a, 0);
        check("R5", "reset fwd_b", ex_fwd_b, 0);
        check("R10", "reset hold", pc_hold, 0);
        check("R10", "reset flush", ifid_flush, 0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            id_rs1 = VECS[i].irs1; id_rs2 = VECS[i].irs2;
            id_is_branch = VECS[i].br; id_br_taken = VECS[i].tk;
            ex_rs1 = VECS[i].ers1; ex_rs2 = VECS[i].ers2; ex_rd = VECS[i].erd;
            ex_wen = VECS[i].ewen; ex_is_load = VECS[i].eld;
            mem_rd = VECS[i].mrd; mem_wen = VECS[i].mwen; mem_is_load = VECS[i].mld;
            wb_rd = VECS[i].wrd; wb_wen = VECS[i].wwen;
            #3;
            begin
                string r;
                r = $sformatf("R%0d", VECS[i].req);
                check(r, $sformatf("vec%0d ex_fwd_a", i), ex_fwd_a, VECS[i].fa);
                check(r, $sformatf("vec%0d ex_fwd_b", i), ex_fwd_b, VECS[i].fb);
                check(r, $sformatf("vec%0d br_fwd_a", i), br_fwd_a, VECS[i].bfa);
                check(r, $sformatf("vec%0d br_fwd_b", i), br_fwd_b, VECS[i].bfb);
                check(r, $sformatf("vec%0d pc_hold", i), pc_hold, VECS[i].stall);
                check(r, $sformatf("vec%0d ifid_hold", i), ifid_hold, VECS[i].stall);
                check(r, $sformatf("vec%0d idex_bubble", i), idex_bubble, VECS[i].stall);
                check(r, $sformatf("vec%0d ifid_flush", i), ifid_flush, VECS[i].flush);
            end
        end

        // Directed R6: load then three dependent readers through a pipeline model.
        prog[0] = '{5'd2, 5'd0, 5'd1, 1'b1, 1'b1, 4'd1};
        prog[1] = '{5'd1, 5'd5, 5'd4, 1'b1, 1'b0, 4'd2};
        prog[2] = '{5'd1, 5'd7, 5'd6, 1'b1, 1'b0, 4'd3};
        prog[3] = '{5'd9, 5'd1, 5'd8, 1'b1, 1'b0, 4'd4};
        s_id = '0; s_ex = '0; s_mem = '0; s_wb = '0;
        pc = 0; stalls = 0;
        for (int cyc = 0; cyc < 9; cyc++) begin
            @(negedge clk);
            drive_model();
            #3;
            if (pc_hold) stalls++;
            if (s_ex.tag == 4'd2) check("R6", "consumer 1 ex_fwd_a", ex_fwd_a, 1);
            if (s_ex.tag == 4'd3) check("R5", "consumer 2 ex_fwd_a", ex_fwd_a, 0);
            if (s_ex.tag == 4'd4) check("R5", "consumer 3 ex_fwd_b", ex_fwd_b, 0);
            s_wb  = s_mem;
            s_mem = s_ex;
            if (idex_bubble) s_ex = '0;
            else             s_ex = s_id;
            if (!ifid_hold) begin
                if (pc < 4) s_id = prog[pc];
                else        s_id = '0;
                pc++;
            end
        end
        check("R6", "load-use stall cycles", stalls, 1);
        check("R7", "instructions issued", pc, 8);

        @(negedge clk);
        summary();
    end

endmodule